// File: doc/BRIEF.md
# Wide-Word Slot Grouping Decoder

This block sits after instruction fetch in a stream-cipher datapath built from four 64-bit operation lanes and one branch-control lane. Each cycle it takes one long instruction word: a 4-bit template, one opcode field per operation lane and one control opcode field. The template states how the four lanes join into wider operations of 64, 128, 192 or 256 bits. It also states whether a control operation issues in the same cycle.

For every lane the decoder reports an enable, the index of the group the lane belongs to, the lane's position inside that group, the width class of the group and the opcode the lane executes. A group always executes the opcode of its first lane. The control slot is reported with its own valid bit and opcode. The compiler guarantees that the slots of a bundle are independent, so the block holds no interlock state. All outputs are registered.

Top module: `vliw_gang_decoder`

## Requirements
- R1: While reset is asserted and until the first bundle is taken, every output is zero.
- R2: A bundle offered with `bnd_valid` high shows on the outputs exactly one clock later. A cycle with `bnd_valid` low gives `lane_en` = 0, `ctl_vld` = 0 and `bnd_illegal` = 0 one clock later.
- R3: Templates 0 and 5 give four independent lanes. Lane n has group n, position 0 and width class 0. Width class is encoded as 0=64, 1=128, 2=192 and 3=256 bits.
- R4: Templates 1 and 6 give two 128-bit pairs. Lanes 0–1 form group 0 and lanes 2–3 form group 1, with positions 0,1,0,1 and width class 1.
- R5: Templates 2 and 7 give one 256-bit group. All lanes are in group 0, with positions 0–3 and width class 3.
- R6: Templates 3 and 8 give two single lanes followed by one pair. Lanes 0 and 1 are groups 0 and 1 with class 0. Lanes 2–3 form group 2 with positions 0,1 and class 1.
- R7: Templates 4 and 9 give one 192-bit triple followed by a single lane. Lanes 0–2 form group 0 with positions 0–2 and class 2. Lane 3 is group 1, position 0, class 0.
- R8: Templates 5–9 set `ctl_vld` and present `bnd_ctl` on `ctl_op`. Templates 0–4 leave `ctl_vld` low.
- R9: Template values 10–15 with `bnd_valid` high set `bnd_illegal` and clear all lane enables and `ctl_vld`.
- R10: Each enabled lane outputs the opcode field of the first lane of its group. The opcode fields of the other lanes in that group have no effect on any output.
- R11: Group, position, width class, lane opcode and control opcode outputs keep their previous values after a cycle without valid bundle and after an illegal bundle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bnd_valid | input | 1 | Bundle present this cycle |
| bnd_tmpl | input | 4 | Layout template |
| bnd_ops | input | 4*OPW | Opcode fields, lane n at bits n*OPW upward |
| bnd_ctl | input | CTLW | Control slot opcode |
| lane_en | output | 4 | Per-lane issue enable |
| lane_grp | output | 8 | 2-bit group index per lane |
| lane_pos | output | 8 | 2-bit position in group per lane |
| lane_wcls | output | 8 | 2-bit width class per lane |
| lane_op | output | 4*OPW | Opcode executed by each lane |
| ctl_vld | output | 1 | Control operation issues |
| ctl_op | output | CTLW | Control opcode |
| bnd_illegal | output | 1 | Illegal template seen |

## Verification
Templates 5 to 9 make the control slot issue in the same cycle as a grouped layout. Both of these decodes then depend on one template value. The bench walks all ten legal templates back to back with distinct opcode fields. On every clock it compares the lane group map, the broadcast group-head opcodes and the control outputs against a behavioural model. A mismatch in either function is caught in that same cycle.

// File: rtl/gang_pkg.sv
package gang_pkg;
  localparam int LANES = 4;
  localparam int FW    = 2;  // width of group, position and width-class fields

  typedef enum logic [2:0] {
    LAY_QUAD_SINGLE = 3'd0,
    LAY_TWO_PAIR    = 3'd1,
    LAY_ONE_QUAD    = 3'd2,
    LAY_SS_PAIR     = 3'd3,
    LAY_TRIPLE_S    = 3'd4
  } layout_e;

  typedef struct packed {
    logic [FW-1:0] grp;
    logic [FW-1:0] pos;
    logic [FW-1:0] wcls;
  } lane_map_t;
endpackage

// File: rtl/gang_tmpl_decode.sv
module gang_tmpl_decode
  import gang_pkg::*;
(
  input  logic [3:0] tmpl,
  output layout_e    lay,
  output logic       with_ctl,
  output logic       legal
);
  localparam logic [3:0] NUM_LAY = 4'd5;
  localparam logic [3:0] NUM_TPL = 4'd10;

  logic [3:0] idx;

  always_comb begin
    legal    = (tmpl < NUM_TPL);
    with_ctl = legal && (tmpl >= NUM_LAY);
    idx      = with_ctl ? (tmpl - NUM_LAY) : tmpl;
    lay      = legal ? layout_e'(idx[2:0]) : LAY_QUAD_SINGLE;
  end
endmodule

// File: rtl/gang_lane_map.sv
module gang_lane_map
  import gang_pkg::*;
#(
  parameter int LANE = 0
) (
  input  layout_e   lay,
  output lane_map_t map
);
  always_comb begin
    map = '0;
    unique case (lay)
      LAY_QUAD_SINGLE: begin
        map.grp  = FW'(LANE);
        map.pos  = '0;
        map.wcls = 2'd0;
      end
      LAY_TWO_PAIR: begin
        map.grp  = FW'(LANE / 2);
        map.pos  = FW'(LANE % 2);
        map.wcls = 2'd1;
      end
      LAY_ONE_QUAD: begin
        map.grp  = '0;
        map.pos  = FW'(LANE);
        map.wcls = 2'd3;
      end
      LAY_SS_PAIR: begin
        if (LANE < 2) begin
          map.grp  = FW'(LANE);
          map.pos  = '0;
          map.wcls = 2'd0;
        end else begin
          map.grp  = 2'd2;
          map.pos  = FW'(LANE - 2);
          map.wcls = 2'd1;
        end
      end
      LAY_TRIPLE_S: begin
        if (LANE < 3) begin
          map.grp  = '0;
          map.pos  = FW'(LANE);
          map.wcls = 2'd2;
        end else begin
          map.grp  = 2'd1;
          map.pos  = '0;
          map.wcls = 2'd0;
        end
      end
      default: map = '0;
    endcase
  end
endmodule

// File: rtl/vliw_gang_decoder.sv
module vliw_gang_decoder
  import gang_pkg::*;
#(
  parameter int OPW  = 8,
  parameter int CTLW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bnd_valid,
  input  logic [3:0]            bnd_tmpl,
  input  logic [LANES*OPW-1:0]  bnd_ops,
  input  logic [CTLW-1:0]       bnd_ctl,
  output logic [LANES-1:0]      lane_en,
  output logic [LANES*FW-1:0]   lane_grp,
  output logic [LANES*FW-1:0]   lane_pos,
  output logic [LANES*FW-1:0]   lane_wcls,
  output logic [LANES*OPW-1:0]  lane_op,
  output logic                  ctl_vld,
  output logic [CTLW-1:0]       ctl_op,
  output logic                  bnd_illegal
);
  layout_e lay;
  logic    with_ctl, legal;

  gang_tmpl_decode u_tdec (
    .tmpl     (bnd_tmpl),
    .lay      (lay),
    .with_ctl (with_ctl),
    .legal    (legal)
  );

  // next-state signals
  logic                 load_fields;
  logic [LANES-1:0]     en_d;
  logic                 ill_d, cv_d;
  lane_map_t            map_d [LANES];
  logic [OPW-1:0]       op_d  [LANES];

  // registers
  logic [LANES-1:0]     en_q;
  logic                 ill_q, cv_q;
  lane_map_t            map_q [LANES];
  logic [OPW-1:0]       op_q  [LANES];
  logic [CTLW-1:0]      cop_q;

  always_comb begin
    load_fields = bnd_valid && legal;
    en_d        = load_fields ? '1 : '0;
    ill_d       = bnd_valid && !legal;
    cv_d        = load_fields && with_ctl;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [FW-1:0] head;

    gang_lane_map #(.LANE(l)) u_map (
      .lay (lay),
      .map (map_d[l])
    );

    always_comb begin
      head     = FW'(l) - map_d[l].pos;
      op_d[l]  = bnd_ops[head*OPW +: OPW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[l] <= '0;
        op_q[l]  <= '0;
      end else if (load_fields) begin
        map_q[l] <= map_d[l];
        op_q[l]  <= op_d[l];
      end
    end

    assign lane_grp [l*FW +: FW]   = map_q[l].grp;
    assign lane_pos [l*FW +: FW]   = map_q[l].pos;
    assign lane_wcls[l*FW +: FW]   = map_q[l].wcls;
    assign lane_op  [l*OPW +: OPW] = op_q[l];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ill_q <= 1'b0;
      cv_q  <= 1'b0;
    end else begin
      en_q  <= en_d;
      ill_q <= ill_d;
      cv_q  <= cv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cop_q <= '0;
    else if (load_fields) cop_q <= bnd_ctl;
  end

  assign lane_en     = en_q;
  assign bnd_illegal = ill_q;
  assign ctl_vld     = cv_q;
  assign ctl_op      = cop_q;

  // R9: an illegal bundle never issues anything
  p_illegal_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_illegal |-> (lane_en == '0) && !ctl_vld);

  // R2: one-cycle latency, idle cycle gives no issue
  p_idle_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bnd_valid) |-> (lane_en == '0) && !ctl_vld && !bnd_illegal);

  // R8: control templates issue the control slot
  p_ctl_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bnd_valid) && ($past(bnd_tmpl) >= 4'd5) && ($past(bnd_tmpl) <= 4'd9)) |-> ctl_vld);

  // R10: lane 0 always heads its group
  p_lane0_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lane_en[0] |-> (lane_pos[FW-1:0] == '0));

  // R11: descriptive fields hold without a legal bundle
  p_fields_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bnd_valid) |-> $stable(lane_grp) && $stable(lane_op) && $stable(ctl_op));
endmodule

// File: tb/vliw_gang_decoder_tb_top.sv
module vliw_gang_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPW  = 8;
  localparam int CTLW = 8;
  localparam int WDOG = 200000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bnd_valid;
  logic [3:0]      bnd_tmpl;
  logic [4*OPW-1:0] bnd_ops;
  logic [CTLW-1:0] bnd_ctl;
  logic [3:0]      lane_en;
  logic [7:0]      lane_grp, lane_pos, lane_wcls;
  logic [4*OPW-1:0] lane_op;
  logic            ctl_vld;
  logic [CTLW-1:0] ctl_op;
  logic            bnd_illegal;

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_gang_decoder #(.OPW(OPW), .CTLW(CTLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .bnd_tmpl(bnd_tmpl),
    .bnd_ops(bnd_ops), .bnd_ctl(bnd_ctl), .lane_en(lane_en),
    .lane_grp(lane_grp), .lane_pos(lane_pos), .lane_wcls(lane_wcls),
    .lane_op(lane_op), .ctl_vld(ctl_vld), .ctl_op(ctl_op),
    .bnd_illegal(bnd_illegal)
  );

  int checks = 0;
  int errors = 0;

  // expected state of the model
  logic [3:0]       e_en;
  logic [7:0]       e_grp, e_pos, e_wcls;
  logic [4*OPW-1:0] e_op;
  logic             e_cv, e_ill;
  logic [CTLW-1:0]  e_cop;
  string            cur_tag;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(cur_tag, "lane_en",   32'(lane_en),   32'(e_en));
    chk(cur_tag, "lane_grp",  32'(lane_grp),  32'(e_grp));
    chk(cur_tag, "lane_pos",  32'(lane_pos),  32'(e_pos));
    chk(cur_tag, "lane_wcls", 32'(lane_wcls), 32'(e_wcls));
    chk(cur_tag == "R1" ? "R1" : "R10", "lane_op", 32'(lane_op), 32'(e_op));
    chk(cur_tag == "R1" ? "R1" : "R8", "ctl_vld", 32'(ctl_vld), 32'(e_cv));
    chk(cur_tag == "R1" ? "R1" : "R8", "ctl_op",  32'(ctl_op),  32'(e_cop));
    chk(cur_tag == "R1" ? "R1" : "R9", "illegal", 32'(bnd_illegal), 32'(e_ill));
  endtask

  function automatic void model(input logic v, input logic [3:0] t,
                                input logic [4*OPW-1:0] ops, input logic [CTLW-1:0] c);
    int sizes[$];
    int lane;
    e_en = '0; e_cv = 1'b0; e_ill = 1'b0;
    if (!v) return;
    if (t >= 10) begin e_ill = 1'b1; return; end
    case (t % 5)
      0: sizes = '{1, 1, 1, 1};
      1: sizes = '{2, 2};
      2: sizes = '{4};
      3: sizes = '{1, 1, 2};
      default: sizes = '{3, 1};
    endcase
    lane = 0;
    foreach (sizes[g]) begin
      for (int p = 0; p < sizes[g]; p++) begin
        e_en[lane] = 1'b1;
        e_grp [lane*2 +: 2] = 2'(g);
        e_pos [lane*2 +: 2] = 2'(p);
        e_wcls[lane*2 +: 2] = 2'(sizes[g] - 1);
        e_op  [lane*OPW +: OPW] = ops[(lane - p)*OPW +: OPW];
        lane++;
      end
    end
    e_cv  = (t >= 5);
    e_cop = c;
  endfunction

  // check what the previous stimulus produced, then apply the next one
  task automatic step(input logic v, input logic [3:0] t, input logic [4*OPW-1:0] ops,
                      input logic [CTLW-1:0] c, input string tag);
    @(negedge clk);
    compare_all();
    bnd_valid = v; bnd_tmpl = t; bnd_ops = ops; bnd_ctl = c;
    model(v, t, ops, c);
    cur_tag = tag;
  endtask

  function automatic string tmpl_tag(input logic [3:0] t);
    if (t >= 10) return "R9";
    case (t % 5)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; bnd_valid = 1'b0; bnd_tmpl = '0; bnd_ops = '0; bnd_ctl = '0;
    e_en = '0; e_grp = '0; e_pos = '0; e_wcls = '0; e_op = '0;
    e_cv = 1'b0; e_ill = 1'b0; e_cop = '0; cur_tag = "R1";
    repeat (3) @(negedge clk);
    compare_all();                       // R1 during reset
    rst_n = 1'b1;
    step(1'b0, 4'd0, '0, '0, "R1");      // R1 after release, nothing taken
    // every legal template, distinct lane fields (R3..R8, R10)
    for (int t = 0; t < 10; t++)
      step(1'b1, 4'(t), {8'(8'hA0 + t), 8'(8'h70 + t), 8'(8'h40 + t), 8'(8'h10 + t)},
           8'(8'hC0 + t), tmpl_tag(4'(t)));
    // R10: only non-head fields change, outputs must not follow
    step(1'b1, 4'd2, 32'h55_66_77_01, 8'h31, "R10");
    step(1'b1, 4'd2, 32'hEE_DD_CC_01, 8'h31, "R10");
    step(1'b1, 4'd9, 32'h09_FF_FE_02, 8'h32, "R10");
    // R2 / R11: idle cycle, fields hold
    step(1'b0, 4'd1, 32'h12_34_56_78, 8'h9A, "R11");
    step(1'b0, 4'd6, 32'h87_65_43_21, 8'h9B, "R2");
    // R9: illegal templates, fields hold
    step(1'b1, 4'd10, 32'hDE_AD_BE_EF, 8'h77, "R9");
    step(1'b1, 4'd15, 32'h0B_AD_F0_0D, 8'h78, "R9");
    step(1'b1, 4'd8,  32'h44_33_22_11, 8'h5E, "R6");
    step(1'b1, 4'd12, 32'hCA_FE_BA_BE, 8'h66, "R9");
    step(1'b0, 4'd0,  '0, '0, "R11");
    // R2: back-to-back layouts
    step(1'b1, 4'd4, 32'hF3_F2_F1_F0, 8'h01, "R7");
    step(1'b1, 4'd6, 32'hE3_E2_E1_E0, 8'h02, "R4");
    step(1'b1, 4'd0, 32'hD3_D2_D1_D0, 8'h03, "R3");
    step(1'b1, 4'd7, 32'hB3_B2_B1_B0, 8'h04, "R5");
    step(1'b0, 4'd0, '0, '0, "R2");
    step(1'b0, 4'd0, '0, '0, "R2");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule